// File: doc/BRIEF.md
# DRAM Start-up and Refresh Sequencer

This block brings a fast-page-mode DRAM array out of power-up and keeps it refreshed. After reset it counts out a fixed power-up pause. It then runs a burst of CAS-before-RAS warm-up cycles. After that, a free-running interval timer raises one refresh demand per interval. For each demand the block asks the access controller for the shared strobes, waits for the grant, and drives RAS and CAS through the CAS-before-RAS order. WE stays high the whole time. No address is driven, because the row counter lives inside the DRAM.

Demands that arrive while the grant is held off are kept in a small backlog and served back to back under a single grant. The interval timer keeps running while the block waits, so late service does not shift later refreshes. A ready flag tells the rest of the chip when normal accesses may begin. All timing values are parameters counted in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, ras_n, cas_n and we_n are 1 and ref_req and init_done are 0.
- R2: ref_req stays 0 for the first PWRUP_CYC cycles after reset is released. It goes to 1 in the cycle that follows the PWRUP_CYC-th rising edge.
- R3: After the pause, exactly INIT_CYC refresh cycles run back to back under one grant. init_done goes to 1 one cycle after ref_req falls at the end of that burst, and it then stays 1 until the next reset.
- R4: Each refresh has three phases. First, cas_n is 0 and ras_n is 1 for T_CSR cycles. Next, both are 0 for T_RAS cycles. Last, both are 1 for T_RP cycles. cas_n never falls again before those T_RP cycles have passed.
- R5: we_n is 1 in every cycle.
- R6: Once init_done is 1, the interval timer expires every INTERVAL_CYC cycles, whatever the grant does. With an immediate grant, successive ref_req rises are exactly INTERVAL_CYC cycles apart.
- R7: Expiries that arrive while the grant is held off are stored, up to MAX_PEND (2 by default). Further expiries are dropped. When the grant comes, all stored refreshes run back to back under one request.
- R8: No refresh starts while ref_gnt is 0. ref_gnt is ignored when no refresh is owed, and it is ignored once a refresh has started: lowering it mid-cycle does not cut the cycle short.
- R9: ref_req is 1 from the moment a refresh is owed, through the last precharge cycle of the burst, and it falls in the first idle cycle. The strobes are active only while ref_req is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_gnt | input | 1 | Grant of the shared strobes from the access controller |
| ref_req | output | 1 | Request for the shared strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (always 1 from this block) |
| init_done | output | 1 | Start-up finished; normal accesses may begin |

## Verification
The hardest state to reach is a full backlog with more expiries still arriving. This needs the grant withheld across several intervals, and the window has to be lined up with the timer phase. The stimulus waits for a request to appear and drops the grant in that same cycle. It then keeps the grant low for just over one interval in one case and just over three intervals in another. The first case fills the backlog exactly, and the second forces expiries to be dropped. A separate case drops the grant in the middle of a strobe sequence, to show that the sequence runs to the end.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CAS  = 2'd1,
      ST_RAS  = 2'd2,
      ST_PRE  = 2'd3
   } seq_st_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/dseq_startup.sv
module dseq_startup #(
   parameter int PWRUP_CYC = 40000,
   parameter int INIT_CYC  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic commit_i,
   input  logic idle_i,
   output logic pwr_done_o,
   output logic init_pend_o,
   output logic init_phase_o,
   output logic init_done_o
);
   localparam int PW = (PWRUP_CYC > 1) ? $clog2(PWRUP_CYC) : 1;
   localparam int IW = $clog2(INIT_CYC + 1);

   logic [PW-1:0] pwr_cnt;
   logic [IW-1:0] init_left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwr_cnt    <= '0;
         pwr_done_o <= 1'b0;
      end else if (!pwr_done_o) begin
         if (pwr_cnt == PW'(PWRUP_CYC - 1)) pwr_done_o <= 1'b1;
         else                               pwr_cnt    <= pwr_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        init_left <= IW'(INIT_CYC);
      else if (commit_i && init_phase_o) init_left <= init_left - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                            init_done_o <= 1'b0;
      else if (pwr_done_o && !init_phase_o && idle_i)        init_done_o <= 1'b1;
   end

   assign init_phase_o = (init_left != '0);
   assign init_pend_o  = pwr_done_o && init_phase_o;

   // R3
   ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done_o |=> init_done_o);
   // R3
   ready_after_warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done_o) |-> (pwr_done_o && !init_phase_o));
endmodule

// File: rtl/dseq_interval.sv
module dseq_interval #(
   parameter int INTERVAL_CYC = 3120
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic tick_o
);
   localparam int TW = $clog2(INTERVAL_CYC);

   logic [TW-1:0] cnt;

   assign tick_o = en_i && (cnt == TW'(INTERVAL_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) cnt <= '0;
      else if (tick_o)     cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   // R6
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/dseq_backlog.sv
module dseq_backlog #(
   parameter int MAX_PEND = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc_i,
   input  logic dec_i,
   output logic owed_o
);
   generate
      if (MAX_PEND == 1) begin : g_flag
         logic owed_q;
         always_ff @(posedge clk) begin
            if (!rst_n)               owed_q <= 1'b0;
            else if (inc_i && !dec_i) owed_q <= 1'b1;
            else if (dec_i && !inc_i) owed_q <= 1'b0;
         end
         assign owed_o = owed_q;
      end else begin : g_count
         localparam int LW = $clog2(MAX_PEND + 1);
         logic [LW-1:0] lvl;
         always_ff @(posedge clk) begin
            if (!rst_n) lvl <= '0;
            else if (inc_i && !dec_i) begin
               if (lvl != LW'(MAX_PEND)) lvl <= lvl + 1'b1;
            end else if (dec_i && !inc_i) lvl <= lvl - 1'b1;
         end
         assign owed_o = (lvl != '0);

         // R7
         pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lvl <= LW'(MAX_PEND));
         // R7
         no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_i && !inc_i) |-> (lvl != '0));
      end
   endgenerate
endmodule

// File: rtl/dseq_strobe.sv
module dseq_strobe
   import dseq_pkg::*;
#(
   parameter int T_CSR = 3,
   parameter int T_RAS = 12,
   parameter int T_RP  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic work_i,
   input  logic gnt_i,
   output logic commit_o,
   output logic busy_o,
   output logic ras_n_o,
   output logic cas_n_o
);
   localparam int PH_MAX = max3(T_CSR, T_RAS, T_RP);
   localparam int CW     = $clog2(PH_MAX + 1);

   seq_st_t       st;
   logic [CW-1:0] ph;
   logic          ph_end;

   always_comb begin
      unique case (st)
         ST_CAS:  ph_end = (ph == CW'(T_CSR - 1));
         ST_RAS:  ph_end = (ph == CW'(T_RAS - 1));
         ST_PRE:  ph_end = (ph == CW'(T_RP - 1));
         default: ph_end = 1'b0;
      endcase
   end

   assign commit_o = work_i && (((st == ST_IDLE) && gnt_i) || ((st == ST_PRE) && ph_end));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         ph <= '0;
      end else begin
         if (commit_o || ph_end) ph <= '0;
         else if (st != ST_IDLE) ph <= ph + 1'b1;
         unique case (st)
            ST_IDLE: if (commit_o) st <= ST_CAS;
            ST_CAS:  if (ph_end)   st <= ST_RAS;
            ST_RAS:  if (ph_end)   st <= ST_PRE;
            default: if (ph_end)   st <= commit_o ? ST_CAS : ST_IDLE;
         endcase
      end
   end

   assign busy_o  = (st != ST_IDLE);
   assign ras_n_o = (st != ST_RAS);
   assign cas_n_o = !((st == ST_CAS) || (st == ST_RAS));

   // R4
   cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));
   // R4
   ras_cas_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n_o) |-> cas_n_o);
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_IDLE) && !gnt_i) |=> (st == ST_IDLE));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
   parameter int PWRUP_CYC    = 40000,
   parameter int INIT_CYC     = 8,
   parameter int INTERVAL_CYC = 3120,
   parameter int T_CSR        = 3,
   parameter int T_RAS        = 12,
   parameter int T_RP         = 8,
   parameter int MIN_RC       = 22,
   parameter int MAX_PEND     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_gnt,
   output logic ref_req,
   output logic ras_n,
   output logic cas_n,
   output logic we_n,
   output logic init_done
);
   localparam int CYC_LEN = T_CSR + T_RAS + T_RP;

   generate
      if (T_CSR < 1)                 begin : bad_csr   $error("T_CSR must be at least 1"); end
      if (T_RAS < 2)                 begin : bad_ras   $error("T_RAS must be at least 2"); end
      if (T_RP < 2)                  begin : bad_rp    $error("T_RP must be at least 2"); end
      if (CYC_LEN < MIN_RC)          begin : bad_rc    $error("refresh cycle shorter than MIN_RC"); end
      if (INTERVAL_CYC <= CYC_LEN)   begin : bad_intv  $error("interval must exceed one refresh"); end
      if (MAX_PEND < 1)              begin : bad_pend  $error("MAX_PEND must be at least 1"); end
      if (PWRUP_CYC < 2)             begin : bad_pwr   $error("PWRUP_CYC must be at least 2"); end
      if (INIT_CYC < 1)              begin : bad_init  $error("INIT_CYC must be at least 1"); end
   endgenerate

   logic pwr_done, init_pend, init_phase;
   logic commit, busy, tick, owed, work;

   dseq_startup #(.PWRUP_CYC(PWRUP_CYC), .INIT_CYC(INIT_CYC)) u_startup (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_i    (commit),
      .idle_i      (!busy),
      .pwr_done_o  (pwr_done),
      .init_pend_o (init_pend),
      .init_phase_o(init_phase),
      .init_done_o (init_done)
   );

   dseq_interval #(.INTERVAL_CYC(INTERVAL_CYC)) u_interval (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (init_done),
      .tick_o(tick)
   );

   dseq_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (tick),
      .dec_i (commit && !init_phase),
      .owed_o(owed)
   );

   assign work = init_pend || owed;

   dseq_strobe #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .work_i  (work),
      .gnt_i   (ref_gnt),
      .commit_o(commit),
      .busy_o  (busy),
      .ras_n_o (ras_n),
      .cas_n_o (cas_n)
   );

   assign ref_req = busy || work;
   assign we_n    = 1'b1;

   // R2
   pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_done |-> (!ref_req && ras_n && cas_n));
   // R9
   strobe_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n || !cas_n) |-> ref_req);
   // R5
   we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> we_n);
endmodule

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/1ps
module test_dram_refresh_seq;
   localparam int PWR  = 100;
   localparam int INIT = 8;
   localparam int CSR  = 3;
   localparam int RASW = 12;
   localparam int RP   = 8;
   localparam int INTV = 200;
   localparam int MAXP = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_gnt = 1'b0;
   logic ref_req, ras_n, cas_n, we_n, init_done;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dram_refresh_seq #(
      .PWRUP_CYC(PWR), .INIT_CYC(INIT), .INTERVAL_CYC(INTV),
      .T_CSR(CSR), .T_RAS(RASW), .T_RP(RP), .MIN_RC(22), .MAX_PEND(MAXP)
   ) i_dram_refresh_seq (
      .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .init_done(init_done)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Behavioural reference: cycles since reset, owed work, phase of a strobe sequence
   int m_cyc = 0, m_left = INIT, m_pend = 0, m_tmr = 0, m_ph = 0, m_pos = 0;
   bit m_rdy = 0;
   bit m_run = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cyc = 0; m_left = INIT; m_pend = 0; m_tmr = 0;
         m_ph = 0; m_pos = 0; m_rdy = 0; m_run = 1;
      end else begin
         bit powered, owes, expire, seq_last, start, ready_nx;
         int left_nx, pend_nx;
         powered  = (m_cyc >= PWR);
         owes     = (powered && m_left > 0) || (m_pend > 0);
         expire   = m_rdy && (m_tmr == INTV - 1);
         seq_last = (m_ph == 3) && (m_pos == RP - 1);
         start    = owes && (((m_ph == 0) && ref_gnt) || seq_last);
         ready_nx = m_rdy || (powered && m_left == 0 && m_ph == 0);
         left_nx  = (start && m_left > 0) ? m_left - 1 : m_left;
         pend_nx  = m_pend;
         if (expire && !(start && m_left == 0)) pend_nx = (m_pend < MAXP) ? m_pend + 1 : MAXP;
         else if (!expire && start && m_left == 0) pend_nx = m_pend - 1;
         if (m_ph == 0) begin
            if (start) begin m_ph = 1; m_pos = 0; end
         end else begin
            int width;
            width = (m_ph == 1) ? CSR : (m_ph == 2) ? RASW : RP;
            if (m_pos == width - 1) begin
               m_pos = 0;
               if (m_ph == 3) m_ph = start ? 1 : 0;
               else           m_ph = m_ph + 1;
            end else m_pos++;
         end
         if (m_rdy) m_tmr = (m_tmr == INTV - 1) ? 0 : m_tmr + 1;
         m_left = left_nx; m_pend = pend_nx; m_rdy = ready_nx;
         m_cyc++;
      end
   end

   // Monitor: compare every cycle, track bursts and request rises
   bit prev_req = 0, prev_cas = 1;
   int burst = 0, last_burst = -1, first_req_cyc = -1, last_rise = -1, prev_rise = -1;

   always @(negedge clk) begin
      if (rst_n && m_run) begin
         bit e_req;
         e_req = (m_ph != 0) || ((m_cyc >= PWR) && m_left > 0) || (m_pend > 0);
         chk("R4", "ras_n", ras_n, (m_ph == 2) ? 0 : 1);
         chk("R4", "cas_n", cas_n, (m_ph == 1 || m_ph == 2) ? 0 : 1);
         chk("R5", "we_n", we_n, 1);
         chk("R3", "init_done", init_done, m_rdy);
         chk((m_cyc < PWR) ? "R2" : "R9", "ref_req", ref_req, e_req);
         if (prev_cas && !cas_n) burst++;
         if (ref_req && !prev_req) begin
            if (first_req_cyc < 0) first_req_cyc = m_cyc;
            prev_rise = last_rise; last_rise = m_cyc;
         end
         if (!ref_req && prev_req) begin last_burst = burst; burst = 0; end
         prev_req = ref_req; prev_cas = cas_n;
      end
   end

   task automatic step(input int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic wait_req(input bit lvl);
      while (ref_req !== lvl) step(1);
   endtask

   initial begin
      step(2);
      // R1: outputs during reset
      chk("R1", "ras_n in reset", ras_n, 1);
      chk("R1", "cas_n in reset", cas_n, 1);
      chk("R1", "we_n in reset", we_n, 1);
      chk("R1", "ref_req in reset", ref_req, 0);
      chk("R1", "init_done in reset", init_done, 0);
      step(2);
      rst_n = 1'b1;
      ref_gnt = 1'b1;

      // R2 / R3: pause, then warm-up burst
      while (!init_done) step(1);
      chk("R2", "cycle of first request", first_req_cyc, PWR);
      chk("R3", "warm-up refresh count", last_burst, INIT);

      // R6: steady refreshes with an immediate grant
      step(450);
      chk("R6", "request spacing", last_rise - prev_rise, INTV);
      chk("R6", "single refresh per request", last_burst, 1);

      // R7: grant withheld over one extra expiry -> two back to back
      wait_req(1'b1);
      ref_gnt = 1'b0;
      step(250);
      chk("R8", "no strobe without grant", cas_n, 1);
      ref_gnt = 1'b1;
      wait_req(1'b0);
      chk("R7", "backlog of two served", last_burst, 2);

      // R7: grant withheld over three extra expiries -> saturates at two
      wait_req(1'b1);
      ref_gnt = 1'b0;
      step(650);
      ref_gnt = 1'b1;
      wait_req(1'b0);
      chk("R7", "saturated backlog served", last_burst, MAXP);

      // R8: grant dropped mid-sequence does not abort it
      wait_req(1'b1);
      while (cas_n) step(1);
      ref_gnt = 1'b0;
      step(6);
      ref_gnt = 1'b1;
      wait_req(1'b0);
      chk("R8", "mid-sequence grant drop", last_burst, 1);

      step(300);
      chk("R3", "ready stays set", init_done, 1);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule